// File: doc/BRIEF.md
# Reference Monitor and Switchover Controller

This block is the digital supervisor of a phase-locked loop that has two candidate reference clocks. Each reference is reduced, upstream of the block, to a one-cycle activity pulse and a level, both synchronous to the monitor clock. The block decides whether each reference is alive. A reference is lost when no pulse arrives inside a window of monitor-clock cycles, and the window has a short and a long setting. The reference is regained only after a run of consecutive on-time pulses.

The controller then picks the reference that drives the phase detector. In manual mode the pick follows a configuration bit. In automatic mode the controller moves away from a failed reference when the other one is alive, and it does not move back when the failed one returns. An optional deglitch holds any change of the pick until both reference levels are low, so that no shortened pulse reaches the detector. When the picked reference is dead, the controller enters holdover and orders the charge pump into high impedance, which leaves the oscillator on its last control voltage. Holdover ends by itself when the picked reference is alive again.

A status pin shows one of eight internal or combined terms, chosen by a select field, in either polarity.

Top module: `refsw_ctrl`

## Requirements
- R1: After reset, `sel_ref1` is 1 (REF1 picked), `ref1_ok` and `ref2_ok` are 0, `holdover` is 1 and `cp_mode` is 2'b00.
- R2: A reference flag that is 1 falls to 0 once the edge input of that reference has been low for the active window of cycles (16 by default, or 48 with the long window). It stays 1 while pulses keep arriving at shorter spacing.
- R3: A reference flag rises on the 4th consecutive pulse, where each pulse follows the previous one by less than the active window. It stays 0 before that pulse.
- R4: `cfg_thr_ext`=0 selects the 16-cycle window and `cfg_thr_ext`=1 selects the 48-cycle window. A reference pulsing every 30 cycles is therefore never valid with the short window and becomes valid with the long one.
- R5: In automatic mode (`cfg_auto`=1), when the picked reference is not ok and the other one is ok, the pick changes to the other one. When the first reference recovers, the pick stays where it is.
- R6: In manual mode (`cfg_auto`=0), `sel_ref1` follows `cfg_man_ref1` (1 = REF1, 0 = REF2), whether or not the requested reference is ok.
- R7: With `cfg_dg_off`=0, the pick changes only on a clock edge where both `ref1_level` and `ref2_level` are sampled low. With `cfg_dg_off`=1, it changes on the next clock edge.
- R8: `holdover` is 1 whenever the picked reference is not ok, and `cp_mode` is then 2'b00 (high impedance).
- R9: `holdover` returns to 0 on the clock edge after the picked reference becomes ok, without any other input.
- R10: Outside holdover, `cp_mode` equals `cfg_cp_mode`. The encodings are 2'b00 high impedance, 2'b01 forced pump up, 2'b10 forced pump down and 2'b11 normal.
- R11: `status` is the term chosen by `cfg_stat_sel`, XORed with `cfg_stat_low`. The codes are: 0 lock, 1 REF1 ok, 2 REF2 ok, 3 `sel_ref1`, 4 holdover, 5 lock AND picked-reference ok AND `vco_ok`, 6 both ok, 7 either ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| ref1_edge | input | 1 | One-cycle activity pulse of REF1 |
| ref2_edge | input | 1 | One-cycle activity pulse of REF2 |
| ref1_level | input | 1 | Synchronised level of REF1 (deglitch) |
| ref2_level | input | 1 | Synchronised level of REF2 (deglitch) |
| dlock | input | 1 | Digital lock indication |
| vco_ok | input | 1 | Oscillator frequency good |
| cfg_auto | input | 1 | 1 = automatic switchover, 0 = manual |
| cfg_man_ref1 | input | 1 | Manual pick, 1 = REF1 |
| cfg_thr_ext | input | 1 | 1 = long loss window |
| cfg_dg_off | input | 1 | 1 = switchover deglitch disabled |
| cfg_cp_mode | input | 2 | Charge-pump mode outside holdover |
| cfg_stat_sel | input | 3 | Status term select |
| cfg_stat_low | input | 1 | 1 = status inverted |
| ref1_ok | output | 1 | REF1 active above threshold |
| ref2_ok | output | 1 | REF2 active above threshold |
| sel_ref1 | output | 1 | Picked reference, 1 = REF1, 0 = REF2 |
| holdover | output | 1 | Holdover active |
| cp_mode | output | 2 | Charge-pump mode |
| status | output | 1 | Multiplexed status |

## Verification
The assertions take for granted that the edge and level inputs are already synchronous to the monitor clock and that each edge is a single-cycle pulse. They also assume the configuration inputs change only between clock edges. The bench generates every pulse and level from per-reference period counters that are updated on the falling clock edge. It changes configuration only at falling edges and holds it for many cycles, so every sampled combination is one that a real synchroniser and a register file could present.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

    typedef enum logic [1:0] {
        CP_HIZ     = 2'b00,
        CP_PUMP_UP = 2'b01,
        CP_PUMP_DN = 2'b10,
        CP_RUN     = 2'b11
    } cp_mode_e;

    typedef enum logic [2:0] {
        ST_LOCK     = 3'd0,
        ST_R1_OK    = 3'd1,
        ST_R2_OK    = 3'd2,
        ST_SEL_R1   = 3'd3,
        ST_HOLD     = 3'd4,
        ST_LOCK_ALL = 3'd5,
        ST_BOTH_OK  = 3'd6,
        ST_ANY_OK   = 3'd7
    } stat_sel_e;

    typedef struct packed {
        logic sel_ref1;
        logic hold;
    } sw_state_t;

    localparam int NUM_REFS = 2;

    // Returns the REF1 term when the pick is REF1, else the REF2 term.
    function automatic logic pick_ref(input logic sel_ref1, input logic t1, input logic t2);
        return sel_ref1 ? t1 : t2;
    endfunction

endpackage

// File: rtl/refsw_act_mon.sv
module refsw_act_mon #(
    parameter int LIM_NORM  = 16,
    parameter int LIM_EXT   = 48,
    parameter int RESTORE_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic thr_ext,
    output logic ok_o
);
    localparam int LIM_MAX = (LIM_EXT > LIM_NORM) ? LIM_EXT : LIM_NORM;
    localparam int CW      = $clog2(LIM_MAX + 1);
    localparam int GW      = $clog2(RESTORE_N + 1);

    logic [CW-1:0] gap_q;
    logic [GW-1:0] run_q;
    logic [GW-1:0] run_nxt;
    logic [CW-1:0] lim;
    logic          expired;
    logic          timeout;
    logic          ok_q;

    assign lim     = thr_ext ? CW'(LIM_EXT) : CW'(LIM_NORM);
    assign expired = (gap_q >= lim);
    assign timeout = ({1'b0, gap_q} + 1'b1) >= {1'b0, lim};
    assign run_nxt = expired ? GW'(1)
                   : (run_q == GW'(RESTORE_N)) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            run_q <= '0;
            ok_q  <= 1'b0;
        end else if (edge_i) begin
            gap_q <= '0;
            run_q <= run_nxt;
            ok_q  <= ok_q | (run_nxt == GW'(RESTORE_N));
        end else begin
            if (gap_q != CW'(LIM_MAX)) gap_q <= gap_q + 1'b1;
            if (timeout) begin
                ok_q  <= 1'b0;
                run_q <= '0;
            end
        end
    end

    assign ok_o = ok_q;
endmodule

// File: rtl/refsw_switch.sv
module refsw_switch
    import refsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ok1,
    input  logic      ok2,
    input  logic      auto_en,
    input  logic      man_ref1,
    input  logic      dg_off,
    input  logic      lvl1,
    input  logic      lvl2,
    output sw_state_t st_o
);
    sw_state_t st_q;
    logic      want_ref1;
    logic      cur_ok;
    logic      oth_ok;
    logic      quiet;
    logic      sel_nxt;

    always_comb begin
        cur_ok = pick_ref(st_q.sel_ref1, ok1, ok2);
        oth_ok = pick_ref(st_q.sel_ref1, ok2, ok1);
        if (auto_en) want_ref1 = (!cur_ok && oth_ok) ? !st_q.sel_ref1 : st_q.sel_ref1;
        else         want_ref1 = man_ref1;
        quiet   = dg_off | (!lvl1 & !lvl2);
        sel_nxt = ((want_ref1 != st_q.sel_ref1) && quiet) ? want_ref1 : st_q.sel_ref1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sel_ref1 <= 1'b1;
            st_q.hold     <= 1'b1;
        end else begin
            st_q.sel_ref1 <= sel_nxt;
            st_q.hold     <= !pick_ref(sel_nxt, ok1, ok2);
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/refsw_stat_mux.sv
module refsw_stat_mux
    import refsw_pkg::*;
(
    input  logic       ok1,
    input  logic       ok2,
    input  logic       sel_ref1,
    input  logic       hold,
    input  logic       dlock,
    input  logic       vco_ok,
    input  logic [2:0] code,
    input  logic       low,
    output logic       status
);
    logic raw;

    always_comb begin
        case (stat_sel_e'(code))
            ST_LOCK:     raw = dlock;
            ST_R1_OK:    raw = ok1;
            ST_R2_OK:    raw = ok2;
            ST_SEL_R1:   raw = sel_ref1;
            ST_HOLD:     raw = hold;
            ST_LOCK_ALL: raw = dlock & pick_ref(sel_ref1, ok1, ok2) & vco_ok;
            ST_BOTH_OK:  raw = ok1 & ok2;
            default:     raw = ok1 | ok2;
        endcase
        status = raw ^ low;
    end
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
    import refsw_pkg::*;
#(
    parameter int LIM_NORM  = 16,
    parameter int LIM_EXT   = 48,
    parameter int RESTORE_N = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref1_edge,
    input  logic       ref2_edge,
    input  logic       ref1_level,
    input  logic       ref2_level,
    input  logic       dlock,
    input  logic       vco_ok,
    input  logic       cfg_auto,
    input  logic       cfg_man_ref1,
    input  logic       cfg_thr_ext,
    input  logic       cfg_dg_off,
    input  logic [1:0] cfg_cp_mode,
    input  logic [2:0] cfg_stat_sel,
    input  logic       cfg_stat_low,
    output logic       ref1_ok,
    output logic       ref2_ok,
    output logic       sel_ref1,
    output logic       holdover,
    output logic [1:0] cp_mode,
    output logic       status
);
    logic [NUM_REFS-1:0] edge_v;
    logic [NUM_REFS-1:0] ok_v;
    sw_state_t           st;

    assign edge_v = {ref2_edge, ref1_edge};

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_mon
        refsw_act_mon #(
            .LIM_NORM (LIM_NORM),
            .LIM_EXT  (LIM_EXT),
            .RESTORE_N(RESTORE_N)
        ) mon_i (
            .clk    (clk),
            .rst    (rst),
            .edge_i (edge_v[i]),
            .thr_ext(cfg_thr_ext),
            .ok_o   (ok_v[i])
        );
    end

    refsw_switch sw_i (
        .clk     (clk),
        .rst     (rst),
        .ok1     (ok_v[0]),
        .ok2     (ok_v[1]),
        .auto_en (cfg_auto),
        .man_ref1(cfg_man_ref1),
        .dg_off  (cfg_dg_off),
        .lvl1    (ref1_level),
        .lvl2    (ref2_level),
        .st_o    (st)
    );

    refsw_stat_mux stat_i (
        .ok1     (ok_v[0]),
        .ok2     (ok_v[1]),
        .sel_ref1(st.sel_ref1),
        .hold    (st.hold),
        .dlock   (dlock),
        .vco_ok  (vco_ok),
        .code    (cfg_stat_sel),
        .low     (cfg_stat_low),
        .status  (status)
    );

    assign ref1_ok  = ok_v[0];
    assign ref2_ok  = ok_v[1];
    assign sel_ref1 = st.sel_ref1;
    assign holdover = st.hold;
    assign cp_mode  = st.hold ? CP_HIZ : cfg_cp_mode;
endmodule

// File: rtl/refsw_chk.sv
module refsw_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref1_edge,
    input logic       ref2_edge,
    input logic       ref1_level,
    input logic       ref2_level,
    input logic       cfg_auto,
    input logic       cfg_man_ref1,
    input logic       cfg_dg_off,
    input logic       ref1_ok,
    input logic       ref2_ok,
    input logic       sel_ref1,
    input logic       holdover,
    input logic [1:0] cp_mode
);
    AST_REF1_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(ref1_ok) |-> $past(ref1_edge)); // R3
    AST_REF2_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(ref2_ok) |-> $past(ref2_edge)); // R3
    AST_REF1_FALL_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(ref1_ok) |-> !$past(ref1_edge)); // R2
    AST_AUTO_LEAVE_DEAD_REF1: assert property (@(posedge clk) disable iff (rst)
        (cfg_auto && cfg_dg_off && sel_ref1 && !ref1_ok && ref2_ok) |=> !sel_ref1); // R5
    AST_AUTO_LEAVE_DEAD_REF2: assert property (@(posedge clk) disable iff (rst)
        (cfg_auto && cfg_dg_off && !sel_ref1 && ref1_ok && !ref2_ok) |=> sel_ref1); // R5
    AST_MANUAL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_auto && cfg_dg_off) |=> (sel_ref1 == $past(cfg_man_ref1))); // R6
    AST_SWITCH_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_ref1) |-> ($past(cfg_dg_off) || $past(!ref1_level && !ref2_level))); // R7
    AST_BOTH_DEAD_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!ref1_ok && !ref2_ok) |=> (holdover && cp_mode == 2'b00)); // R8
    AST_AUTO_RECOVER: assert property (@(posedge clk) disable iff (rst)
        (ref1_ok && sel_ref1 && (cfg_auto || cfg_man_ref1)) |=> !holdover); // R9
endmodule

bind refsw_ctrl refsw_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .ref1_edge   (ref1_edge),
    .ref2_edge   (ref2_edge),
    .ref1_level  (ref1_level),
    .ref2_level  (ref2_level),
    .cfg_auto    (cfg_auto),
    .cfg_man_ref1(cfg_man_ref1),
    .cfg_dg_off  (cfg_dg_off),
    .ref1_ok     (ref1_ok),
    .ref2_ok     (ref2_ok),
    .sel_ref1    (sel_ref1),
    .holdover    (holdover),
    .cp_mode     (cp_mode)
);

// File: tb/refsw_ctrl_tb_top.sv
module refsw_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref1_edge = 1'b0, ref2_edge = 1'b0;
    logic       ref1_level = 1'b0, ref2_level = 1'b0;
    logic       dlock = 1'b1, vco_ok = 1'b1;
    logic       cfg_auto = 1'b1, cfg_man_ref1 = 1'b1, cfg_thr_ext = 1'b0, cfg_dg_off = 1'b0;
    logic [1:0] cfg_cp_mode = 2'b11;
    logic [2:0] cfg_stat_sel = 3'd0;
    logic       cfg_stat_low = 1'b0;
    logic       ref1_ok, ref2_ok, sel_ref1, holdover, status;
    logic [1:0] cp_mode;

    int per1 = 0, per2 = 0, c1 = 0, c2 = 0;
    bit force1 = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    refsw_ctrl dut_i (
        .clk(clk), .rst(rst),
        .ref1_edge(ref1_edge), .ref2_edge(ref2_edge),
        .ref1_level(ref1_level), .ref2_level(ref2_level),
        .dlock(dlock), .vco_ok(vco_ok),
        .cfg_auto(cfg_auto), .cfg_man_ref1(cfg_man_ref1),
        .cfg_thr_ext(cfg_thr_ext), .cfg_dg_off(cfg_dg_off),
        .cfg_cp_mode(cfg_cp_mode), .cfg_stat_sel(cfg_stat_sel),
        .cfg_stat_low(cfg_stat_low),
        .ref1_ok(ref1_ok), .ref2_ok(ref2_ok), .sel_ref1(sel_ref1),
        .holdover(holdover), .cp_mode(cp_mode), .status(status)
    );

    // Reference stimulus: periodic one-cycle pulses and half-period levels.
    always @(negedge clk) begin
        if (per1 == 0) begin c1 = 0; ref1_edge = 1'b0; ref1_level = force1; end
        else begin
            ref1_edge  = (c1 == 0);
            ref1_level = force1 | (c1 < per1 / 2);
            c1 = (c1 + 1 >= per1) ? 0 : c1 + 1;
        end
        if (per2 == 0) begin c2 = 0; ref2_edge = 1'b0; ref2_level = 1'b0; end
        else begin
            ref2_edge  = (c2 == 0);
            ref2_level = (c2 < per2 / 2);
            c2 = (c2 + 1 >= per2) ? 0 : c2 + 1;
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic t_reset();
        // R1
        chk(sel_ref1, 1, "R1", "sel_ref1 after reset");
        chk(ref1_ok, 0, "R1", "ref1_ok after reset");
        chk(ref2_ok, 0, "R1", "ref2_ok after reset");
        chk(holdover, 1, "R1", "holdover after reset");
        chk(cp_mode, 2'b00, "R1", "cp_mode after reset");
    endtask

    task automatic t_restore();
        per1 = 8;
        wcyc(20);
        chk(ref1_ok, 0, "R3", "ref1_ok before 4th pulse");
        wcyc(20);
        chk(ref1_ok, 1, "R3", "ref1_ok after 4th pulse");
        chk(holdover, 0, "R9", "holdover cleared on return");
        chk(cp_mode, 2'b11, "R10", "cp_mode normal");
    endtask

    task automatic t_cp();
        cfg_cp_mode = 2'b01; wcyc(1);
        chk(cp_mode, 2'b01, "R10", "cp_mode pump up");
        cfg_cp_mode = 2'b10; wcyc(1);
        chk(cp_mode, 2'b10, "R10", "cp_mode pump down");
        cfg_cp_mode = 2'b11; wcyc(1);
    endtask

    task automatic t_failover();
        per2 = 10;
        wcyc(60);
        chk(ref2_ok, 1, "R3", "ref2_ok running");
        per1 = 0;
        wcyc(5);
        chk(ref1_ok, 1, "R2", "ref1_ok inside window");
        wcyc(30);
        chk(ref1_ok, 0, "R2", "ref1_ok after window");
        chk(sel_ref1, 0, "R5", "auto switch to REF2");
        chk(holdover, 0, "R8", "no holdover after switch");
        per1 = 8;
        wcyc(60);
        chk(ref1_ok, 1, "R3", "ref1_ok regained");
        chk(sel_ref1, 0, "R5", "no revert to REF1");
    endtask

    task automatic t_both_lost();
        per1 = 0; per2 = 0;
        wcyc(80);
        chk(holdover, 1, "R8", "holdover both lost");
        chk(cp_mode, 2'b00, "R8", "cp_mode hiz in holdover");
        per2 = 10;
        wcyc(60);
        chk(holdover, 0, "R9", "auto recovery on REF2");
        chk(sel_ref1, 0, "R9", "pick still REF2");
        per1 = 8;
        wcyc(60);
    endtask

    task automatic t_manual();
        cfg_auto = 1'b0; cfg_man_ref1 = 1'b1;
        wcyc(20);
        chk(sel_ref1, 1, "R6", "manual pick REF1");
        per1 = 0;
        wcyc(40);
        chk(sel_ref1, 1, "R6", "manual keeps dead REF1");
        chk(holdover, 1, "R8", "holdover on dead manual pick");
        per1 = 8;
        wcyc(60);
        chk(holdover, 0, "R9", "manual recovery");
    endtask

    task automatic t_deglitch();
        force1 = 1; cfg_man_ref1 = 1'b0;
        wcyc(30);
        chk(sel_ref1, 1, "R7", "switch held while REF1 level high");
        force1 = 0;
        wcyc(20);
        chk(sel_ref1, 0, "R7", "switch after both low");
        cfg_dg_off = 1'b1; force1 = 1; cfg_man_ref1 = 1'b1;
        wcyc(2);
        chk(sel_ref1, 1, "R7", "immediate switch, deglitch off");
        force1 = 0; cfg_dg_off = 1'b0; cfg_auto = 1'b1;
        wcyc(5);
    endtask

    task automatic t_threshold();
        per2 = 30; cfg_thr_ext = 1'b0;
        wcyc(200);
        chk(ref2_ok, 0, "R4", "30-cycle ref with short window");
        cfg_thr_ext = 1'b1;
        wcyc(200);
        chk(ref2_ok, 1, "R4", "30-cycle ref with long window");
        per2 = 10; cfg_thr_ext = 1'b0;
        wcyc(60);
    endtask

    task automatic t_status();
        cfg_stat_sel = 3'd0; cfg_stat_low = 1'b0; wcyc(1);
        chk(status, 1, "R11", "lock term");
        cfg_stat_low = 1'b1; wcyc(1);
        chk(status, 0, "R11", "lock term inverted");
        cfg_stat_sel = 3'd3; cfg_stat_low = 1'b0; wcyc(1);
        chk(status, 1, "R11", "picked ref term");
        cfg_stat_sel = 3'd5; vco_ok = 1'b0; wcyc(1);
        chk(status, 0, "R11", "combined term vco bad");
        vco_ok = 1'b1; wcyc(1);
        chk(status, 1, "R11", "combined term good");
        cfg_stat_sel = 3'd6; wcyc(1);
        chk(status, 1, "R11", "both ok term");
        cfg_stat_sel = 3'd4; wcyc(1);
        chk(status, 0, "R11", "holdover term");
        cfg_stat_low = 1'b1; wcyc(1);
        chk(status, 1, "R11", "holdover term inverted");
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wcyc(4);
        rst = 1'b0;
        wcyc(1);
        t_reset();
        t_restore();
        t_cp();
        t_failover();
        t_both_lost();
        t_manual();
        t_deglitch();
        t_threshold();
        t_status();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule